// File: doc/BRIEF.md
# Relocated-Execute Fault Status Controller

This block keeps the fault status word of a page-mapping unit and turns fault events into either an interrupt request or a skip indication. While the processor runs an instruction under relocated execute, two control bits pick the address space for each memory cycle. One bit covers pure reads. The other covers writes and read-modify-write cycles. The block registers that choice for every cycle the sequencer presents.

When the translator reports a page fault, the reason bits are always recorded. If the relocated-execute inhibit bit is clear, the fault bit is also set and an interrupt is requested. If the inhibit bit is set, the fault bit is left alone and a one-cycle skip pulse is produced instead, so the sequencer can resume two words past the relocated instruction. Software can later raise the fault bit with a force command, which keeps the recorded reasons. Other status sources are single-step completion, address-break matches and an 18-bit per-user quantum timer. The timer counts microsecond ticks except while an interrupt is being serviced. The status word and the timer can both be reloaded, so per-user state can be swapped.

Top module: `xr_fault_ctl`

## Requirements
- R1: After reset, status is 12'h020 (only the fixed exec-mapping bit 5 set), quantum is 0, and irq, skip and cyc_user are 0.
- R2: One cycle after a cycle request with kind 2'b00 (pure read), cyc_user equals xr_rd_user if xr_active is high and is 0 otherwise.
- R3: One cycle after a cycle request with kind 2'b01 (write) or 2'b10 (read-modify-write), cyc_user equals xr_wr_user if xr_active is high. Kind 2'b11 and idle cycles give 0.
- R4: A page fault (pf_valid) overwrites status bits 9..6 with pf_reason[3:0] (bit 9 nonexistent memory, 8 write to write-first page, 7 no access, 6 write to read-only), whatever the inhibit bit.
- R5: A page fault with inhibit not in effect sets the fault bit (bit 10).
- R6: A page fault with xr_active and xr_inhibit both high leaves bit 10 unchanged and raises skip for exactly the next cycle. No other event raises skip.
- R7: force_fault sets bit 10 and leaves bits 9..6 unchanged.
- R8: insn_done with one_proc_flag high sets the single-step bit (bit 11).
- R9: With tick_us high and pi_busy low, quantum increments by one. With pi_busy high, quantum holds.
- R10: A counted tick at quantum 18'h3FFFF wraps it to 0 and sets the quantum overflow bit (bit 3).
- R11: brk_match sets the address-break bit (bit 4).
- R12: irq is high exactly when any of bits 11, 10, 4 or 3 is set, and it stays high until those bits are cleared.
- R13: clr_status returns status to 12'h020 in one cycle and wins over any event or load in the same cycle.
- R14: ld_valid loads quantum from ld_quantum and status from ld_status, with bit 5 forced to 1 and bits 2..0 forced to 0. The load wins over events and ticks in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xr_active | input | 1 | Relocated execute in progress |
| xr_rd_user | input | 1 | User space for pure reads |
| xr_wr_user | input | 1 | User space for writes and read-modify-writes |
| xr_inhibit | input | 1 | Suppress the fault bit and skip instead |
| cyc_valid | input | 1 | Memory cycle request |
| cyc_kind | input | 2 | 00 read, 01 write, 10 read-modify-write |
| pf_valid | input | 1 | Page fault event |
| pf_reason | input | 4 | Fault reason bits |
| force_fault | input | 1 | Set the fault bit, keep the reasons |
| insn_done | input | 1 | Instruction completed |
| one_proc_flag | input | 1 | Single-step flag of the PC |
| brk_match | input | 1 | Address-break match |
| tick_us | input | 1 | Microsecond strobe |
| pi_busy | input | 1 | Interrupt in progress |
| clr_status | input | 1 | Clear status |
| ld_valid | input | 1 | Load saved state |
| ld_status | input | 12 | Status value to load |
| ld_quantum | input | 18 | Quantum value to load |
| cyc_user | output | 1 | Registered user-space select |
| status | output | 12 | Fault status word |
| quantum | output | 18 | Quantum timer |
| irq | output | 1 | Interrupt request |
| skip | output | 1 | Skip pulse |

## Verification
The space select is driven with every cycle kind, both inside and outside relocated execute, with the two select bits set opposite to each other. This shows which bit governs reads and which governs read-modify-write cycles. Faults are raised with and without inhibit, and the sequence of inhibited fault followed by force fault is run to check that the reasons survive. Clear and load are issued in the same cycle as events to check priority. The timer is loaded just below its wrap point and ticked with the interrupt-busy input both high and low. Random mixes of all inputs are compared with a bench model, cycle by cycle.

// File: rtl/xr_fault_pkg.sv
package xr_fault_pkg;
  localparam int SW       = 12;
  localparam int RW       = 4;
  localparam int B_ONEP   = 11;
  localparam int B_FAULT  = 10;
  localparam int B_RSN_HI = 9;
  localparam int B_RSN_LO = 6;
  localparam int B_EXMAP  = 5;
  localparam int B_BRK    = 4;
  localparam int B_QOVF   = 3;
  localparam logic [SW-1:0] ST_RESET = 12'h020;
  localparam logic [SW-1:0] ST_LDMASK = 12'hFD8;
  localparam logic [SW-1:0] ST_IRQMASK = 12'hC18;

  typedef enum logic [1:0] {
    CYC_RD  = 2'b00,
    CYC_WR  = 2'b01,
    CYC_RMW = 2'b10,
    CYC_NONE = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/xr_space_sel.sv
module xr_space_sel
  import xr_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xr_active,
  input  logic       xr_rd_user,
  input  logic       xr_wr_user,
  input  logic       cyc_valid,
  input  logic [1:0] cyc_kind,
  output logic       cyc_user
);
  logic sel_n;

  always_comb begin
    sel_n = 1'b0;
    if (cyc_valid && xr_active) begin
      case (cyc_kind_e'(cyc_kind))
        CYC_RD:          sel_n = xr_rd_user;
        CYC_WR, CYC_RMW: sel_n = xr_wr_user;
        default:         sel_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cyc_user <= 1'b0;
    else     cyc_user <= sel_n;
  end
endmodule

// File: rtl/xr_quantum.sv
module xr_quantum #(
  parameter int QW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hold,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  output logic [QW-1:0] count,
  output logic          wrap
);
  localparam logic [QW-1:0] QMAX = {QW{1'b1}};
  logic step;

  assign step = tick && !hold && !load;
  assign wrap = step && (count == QMAX);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/xr_status.sv
module xr_status
  import xr_fault_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pf_valid,
  input  logic [RW-1:0] pf_reason,
  input  logic          inhibit_on,
  input  logic          force_fault,
  input  logic          onep_evt,
  input  logic          brk_evt,
  input  logic          qovf_evt,
  input  logic          clr,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  output logic [SW-1:0] status,
  output logic          irq,
  output logic          skip
);
  logic [SW-1:0] nxt;

  always_comb begin
    nxt = status;
    if (clr) begin
      nxt = ST_RESET;
    end else if (load) begin
      nxt = (load_val & ST_LDMASK) | ST_RESET;
    end else begin
      if (pf_valid) begin
        nxt[B_RSN_HI:B_RSN_LO] = pf_reason;
        if (!inhibit_on) nxt[B_FAULT] = 1'b1;
      end
      if (force_fault) nxt[B_FAULT] = 1'b1;
      if (onep_evt)    nxt[B_ONEP]  = 1'b1;
      if (brk_evt)     nxt[B_BRK]   = 1'b1;
      if (qovf_evt)    nxt[B_QOVF]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= ST_RESET;
      irq    <= 1'b0;
      skip   <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |(nxt & ST_IRQMASK);
      skip   <= pf_valid && inhibit_on;
    end
  end
endmodule

// File: rtl/xr_fault_ctl.sv
module xr_fault_ctl
  import xr_fault_pkg::*;
#(
  parameter int QW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xr_active,
  input  logic          xr_rd_user,
  input  logic          xr_wr_user,
  input  logic          xr_inhibit,
  input  logic          cyc_valid,
  input  logic [1:0]    cyc_kind,
  input  logic          pf_valid,
  input  logic [3:0]    pf_reason,
  input  logic          force_fault,
  input  logic          insn_done,
  input  logic          one_proc_flag,
  input  logic          brk_match,
  input  logic          tick_us,
  input  logic          pi_busy,
  input  logic          clr_status,
  input  logic          ld_valid,
  input  logic [11:0]   ld_status,
  input  logic [QW-1:0] ld_quantum,
  output logic          cyc_user,
  output logic [11:0]   status,
  output logic [QW-1:0] quantum,
  output logic          irq,
  output logic          skip
);
  logic q_wrap;

  xr_space_sel u_sel (
    .clk(clk), .rst(rst), .xr_active(xr_active), .xr_rd_user(xr_rd_user),
    .xr_wr_user(xr_wr_user), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
    .cyc_user(cyc_user)
  );

  xr_quantum #(.QW(QW)) u_q (
    .clk(clk), .rst(rst), .tick(tick_us), .hold(pi_busy), .load(ld_valid),
    .load_val(ld_quantum), .count(quantum), .wrap(q_wrap)
  );

  xr_status u_st (
    .clk(clk), .rst(rst), .pf_valid(pf_valid), .pf_reason(pf_reason),
    .inhibit_on(xr_active && xr_inhibit), .force_fault(force_fault),
    .onep_evt(insn_done && one_proc_flag), .brk_evt(brk_match),
    .qovf_evt(q_wrap), .clr(clr_status), .load(ld_valid),
    .load_val(ld_status), .status(status), .irq(irq), .skip(skip)
  );
endmodule

// File: rtl/xr_fault_ctl_chk.sv
module xr_fault_ctl_chk #(
  parameter int QW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          xr_active,
  input logic          xr_inhibit,
  input logic          cyc_valid,
  input logic          pf_valid,
  input logic [3:0]    pf_reason,
  input logic          force_fault,
  input logic          tick_us,
  input logic          pi_busy,
  input logic          clr_status,
  input logic          ld_valid,
  input logic          cyc_user,
  input logic [11:0]   status,
  input logic [QW-1:0] quantum,
  input logic          irq,
  input logic          skip
);
  assert_idle_kernel_R2: assert property (@(posedge clk) disable iff (rst)
    (!cyc_valid || !xr_active) |=> !cyc_user);

  assert_reason_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !clr_status && !ld_valid) |=> status[9:6] == $past(pf_reason));

  assert_fault_set_R5: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !(xr_active && xr_inhibit) && !clr_status && !ld_valid) |=> status[10]);

  assert_inhibit_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && xr_active && xr_inhibit && !force_fault && !clr_status && !ld_valid)
      |=> (status[10] == $past(status[10])) && skip);

  assert_skip_source_R6: assert property (@(posedge clk) disable iff (rst)
    !(pf_valid && xr_active && xr_inhibit) |=> !skip);

  assert_force_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (force_fault && !pf_valid && !clr_status && !ld_valid)
      |=> status[10] && $stable(status[9:6]));

  assert_pi_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (pi_busy && !ld_valid) |=> $stable(quantum));

  assert_irq_or_R12: assert property (@(posedge clk) disable iff (rst)
    irq == (status[11] || status[10] || status[4] || status[3]));

  assert_clear_R13: assert property (@(posedge clk) disable iff (rst)
    clr_status |=> (status == 12'h020) && !irq);

  assert_fixed_bits_R14: assert property (@(posedge clk) disable iff (rst)
    status[5] && (status[2:0] == 3'b000));
endmodule

bind xr_fault_ctl xr_fault_ctl_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst(rst), .xr_active(xr_active), .xr_inhibit(xr_inhibit),
  .cyc_valid(cyc_valid), .pf_valid(pf_valid), .pf_reason(pf_reason),
  .force_fault(force_fault), .tick_us(tick_us), .pi_busy(pi_busy),
  .clr_status(clr_status), .ld_valid(ld_valid), .cyc_user(cyc_user),
  .status(status), .quantum(quantum), .irq(irq), .skip(skip)
);

// File: tb/xr_fault_ctl_tb.sv
`timescale 1ns/1ps
module xr_fault_ctl_tb;
  localparam int QW = 18;
  logic clk = 1'b0;
  logic rst;
  logic xr_active, xr_rd_user, xr_wr_user, xr_inhibit, cyc_valid;
  logic [1:0] cyc_kind;
  logic pf_valid, force_fault, insn_done, one_proc_flag, brk_match;
  logic [3:0] pf_reason;
  logic tick_us, pi_busy, clr_status, ld_valid;
  logic [11:0] ld_status;
  logic [QW-1:0] ld_quantum;
  logic cyc_user, irq, skip;
  logic [11:0] status;
  logic [QW-1:0] quantum;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [11:0] e_st;
  logic [QW-1:0] e_q;
  logic e_irq, e_skip, e_cyc;

  always #2.5 clk = ~clk;

  xr_fault_ctl #(.QW(QW)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic sel_model(logic v, logic xa, logic [1:0] k, logic rd, logic wr);
    if (!v || !xa) return 1'b0;
    if (k == 2'b00) return rd;
    if (k == 2'b01 || k == 2'b10) return wr;
    return 1'b0;
  endfunction

  task automatic idle();
    xr_active = 0; xr_rd_user = 0; xr_wr_user = 0; xr_inhibit = 0;
    cyc_valid = 0; cyc_kind = 0; pf_valid = 0; pf_reason = 0;
    force_fault = 0; insn_done = 0; one_proc_flag = 0; brk_match = 0;
    tick_us = 0; pi_busy = 0; clr_status = 0; ld_valid = 0;
    ld_status = 0; ld_quantum = 0;
  endtask

  // advance one clock, update the model from the driven inputs
  task automatic step();
    logic ovf;
    logic inh;
    @(posedge clk);
    ovf = 1'b0;
    inh = xr_active && xr_inhibit;
    e_cyc = sel_model(cyc_valid, xr_active, cyc_kind, xr_rd_user, xr_wr_user);
    e_skip = pf_valid && inh;
    if (ld_valid) e_q = ld_quantum;
    else if (tick_us && !pi_busy) begin
      ovf = (e_q == {QW{1'b1}});
      e_q = e_q + 1'b1;
    end
    if (clr_status) e_st = 12'h020;
    else if (ld_valid) e_st = (ld_status & 12'hFD8) | 12'h020;
    else begin
      if (pf_valid) begin
        e_st[9:6] = pf_reason;
        if (!inh) e_st[10] = 1'b1;
      end
      if (force_fault) e_st[10] = 1'b1;
      if (insn_done && one_proc_flag) e_st[11] = 1'b1;
      if (brk_match) e_st[4] = 1'b1;
      if (ovf) e_st[3] = 1'b1;
    end
    e_irq = |(e_st & 12'hC18);
    #1;
  endtask

  task automatic check_all(input string ts, input string tq, input string ti);
    chk(ts, 32'(status), 32'(e_st));
    chk(tq, 32'(quantum), 32'(e_q));
    chk(ti, 32'(irq), 32'(e_irq));
    chk("R6 skip", 32'(skip), 32'(e_skip));
    chk("R2 cyc_user", 32'(cyc_user), 32'(e_cyc));
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    e_st = 12'h020; e_q = '0; e_irq = 0; e_skip = 0; e_cyc = 0;
    #1;
    // R1 reset state
    chk("R1 status", 32'(status), 32'h020);
    chk("R1 quantum", 32'(quantum), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 skip", 32'(skip), 0);
    chk("R1 cyc_user", 32'(cyc_user), 0);

    // R2 read select, opposite bits
    @(negedge clk); idle(); cyc_valid = 1; xr_active = 1; xr_rd_user = 1; cyc_kind = 2'b00;
    step(); chk("R2 read uses rd bit", 32'(cyc_user), 1);
    @(negedge clk); xr_rd_user = 0; xr_wr_user = 1;
    step(); chk("R2 read ignores wr bit", 32'(cyc_user), 0);
    @(negedge clk); xr_active = 0; xr_rd_user = 1;
    step(); chk("R2 no xr gives exec", 32'(cyc_user), 0);
    // R3 write / rmw
    @(negedge clk); xr_active = 1; xr_rd_user = 0; xr_wr_user = 1; cyc_kind = 2'b10;
    step(); chk("R3 rmw uses wr bit", 32'(cyc_user), 1);
    @(negedge clk); xr_rd_user = 1; xr_wr_user = 0; cyc_kind = 2'b01;
    step(); chk("R3 write ignores rd bit", 32'(cyc_user), 0);
    @(negedge clk); xr_wr_user = 1; cyc_kind = 2'b11;
    step(); chk("R3 kind 11", 32'(cyc_user), 0);

    // R6 inhibited fault, then R7 force keeps reasons
    @(negedge clk); idle(); pf_valid = 1; pf_reason = 4'b0101; xr_active = 1; xr_inhibit = 1;
    step();
    chk("R4 reasons latched", 32'(status[9:6]), 32'h5);
    chk("R6 fault bit clear", 32'(status[10]), 0);
    chk("R6 skip pulse", 32'(skip), 1);
    chk("R6 no irq", 32'(irq), 0);
    @(negedge clk); idle();
    step(); chk("R6 skip one cycle", 32'(skip), 0);
    @(negedge clk); force_fault = 1;
    step();
    chk("R7 force sets fault", 32'(status), 32'h560);
    chk("R12 irq from fault", 32'(irq), 1);
    @(negedge clk); idle();
    repeat (3) step();
    chk("R12 irq held", 32'(irq), 1);

    // R13 clear wins over events
    @(negedge clk); clr_status = 1; brk_match = 1; pf_valid = 1; pf_reason = 4'hF; ld_valid = 1; ld_status = 12'hFFF;
    step();
    chk("R13 clear priority", 32'(status), 32'h020);
    chk("R13 irq drops", 32'(irq), 0);

    // R5 uninhibited fault, inhibit bit without xr_active
    @(negedge clk); idle(); pf_valid = 1; pf_reason = 4'b1010; xr_inhibit = 1;
    step();
    chk("R5 fault sets bit10", 32'(status), 32'h6A0);
    chk("R5 no skip", 32'(skip), 0);

    // R8, R11
    @(negedge clk); idle(); clr_status = 1; step();
    @(negedge clk); idle(); insn_done = 1; one_proc_flag = 0; step();
    chk("R8 no flag no set", 32'(status), 32'h020);
    @(negedge clk); one_proc_flag = 1; step();
    chk("R8 one proceed", 32'(status), 32'h820);
    chk("R12 irq from onep", 32'(irq), 1);
    @(negedge clk); idle(); clr_status = 1; step();
    @(negedge clk); idle(); brk_match = 1; step();
    chk("R11 break bit", 32'(status), 32'h030);
    chk("R12 irq from break", 32'(irq), 1);

    // R14 load, R9, R10
    @(negedge clk); idle(); ld_valid = 1; ld_status = 12'h1C7; ld_quantum = 18'h3FFFE; tick_us = 1; brk_match = 1;
    step();
    chk("R14 status load masked", 32'(status), 32'h1E0);
    chk("R14 quantum load", 32'(quantum), 32'h3FFFE);
    @(negedge clk); idle(); tick_us = 1; pi_busy = 1; step();
    chk("R9 hold in pi", 32'(quantum), 32'h3FFFE);
    @(negedge clk); pi_busy = 0; step();
    chk("R9 increment", 32'(quantum), 32'h3FFFF);
    chk("R10 no ovf yet", 32'(status[3]), 0);
    step();
    chk("R10 wrap", 32'(quantum), 0);
    chk("R10 ovf bit", 32'(status), 32'h1E8);
    chk("R12 irq from ovf", 32'(irq), 1);

    // random mix against model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      xr_active = $urandom_range(0, 1); xr_rd_user = $urandom_range(0, 1);
      xr_wr_user = $urandom_range(0, 1); xr_inhibit = $urandom_range(0, 1);
      cyc_valid = $urandom_range(0, 1); cyc_kind = 2'($urandom_range(0, 3));
      pf_valid = ($urandom_range(0, 7) == 0); pf_reason = 4'($urandom);
      force_fault = ($urandom_range(0, 15) == 0);
      insn_done = $urandom_range(0, 1); one_proc_flag = ($urandom_range(0, 15) == 0);
      brk_match = ($urandom_range(0, 31) == 0);
      tick_us = $urandom_range(0, 1); pi_busy = ($urandom_range(0, 3) == 0);
      clr_status = ($urandom_range(0, 15) == 0);
      ld_valid = ($urandom_range(0, 63) == 0); ld_status = 12'($urandom);
      ld_quantum = ($urandom_range(0, 1) == 1) ? 18'h3FFF0 : QW'($urandom);
      step();
      check_all("R4 status model", "R9 quantum model", "R12 irq model");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule